// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns three digital Hall-sensor levels into drive enables for the three high-side (source) and three low-side (sink) switches of a brushless motor bridge. The Hall levels first pass through a synchronizer. A fixed six-state table then selects exactly one source phase and one sink phase. Reverse rotation uses the same table, indexed by the complemented Hall code.

A run/stop input, a drive-mode select and three shutdown flags gate the result. The shutdown flags are a lock-protection latch, an undervoltage flag and an over-temperature flag. In direct-PWM mode the source group is chopped by an external PWM signal, and an auxiliary output carries the synchronized tachometer comparator level. In amplitude mode the source group is not chopped, and the auxiliary output carries the PWM signal so that it can drive an external supply regulator.

Every change of the Hall state or of the direction input blanks all six outputs for a programmable number of clock cycles. This gives the external switches dead time.

Top module: `hall_commutator`

## Requirements
- R1: With `dirRev` low, the Hall code {`hallIn[2]`,`hallIn[1]`,`hallIn[0]`} drives the following source/sink phases, with phase bits bit0=U, bit1=V and bit2=W: 101 gives source V, sink U; 100 gives W, U; 110 gives W, V; 010 gives U, V; 011 gives U, W; 001 gives V, W.
- R2: With `dirRev` high, the decoder selects the row of the R1 table whose code is the bitwise complement of the Hall code. For example, 010 gives source V, sink U.
- R3: The Hall codes 000 and 111 turn all six outputs off.
- R4: `stopReq` high turns all six outputs off one cycle later. `stopReq` low allows drive.
- R5: When the synchronized Hall code or `dirRev` changes, all outputs are off for `deadCycles` cycles before the new state appears. A value of 0 gives no blanking. A Hall change reaches the outputs SYNC_STAGES+1 edges after it is applied.
- R6: With `modeAmp` low (direct-PWM mode), `srcOut` is the decoded source pattern ANDed with `pwmIn`, registered once. `snkOut` is not affected by `pwmIn`.
- R7: `auxOut` is the synchronized `tachIn` when `modeAmp` is low. It is `pwmIn`, registered once, when `modeAmp` is high, and in that mode `srcOut` ignores `pwmIn`.
- R8: `underVolt` high or `lockTrip` high turns `snkOut` off and leaves `srcOut` unchanged.
- R9: `overTemp` high turns all six outputs off while it is high. Drive resumes one cycle after it falls.
- R10: In every valid driven state exactly one source bit and one sink bit are set, and they belong to different phases.
- R11: While `rstN` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallIn | input | 3 | Hall levels, bit2 = sensor 1, bit0 = sensor 3 |
| tachIn | input | 1 | Tachometer comparator level |
| dirRev | input | 1 | 1 = reverse rotation |
| stopReq | input | 1 | 1 = stop (all drive off) |
| modeAmp | input | 1 | 1 = amplitude mode, 0 = direct-PWM mode |
| pwmIn | input | 1 | PWM chopping signal |
| lockTrip | input | 1 | Motor-lock protection latch active |
| underVolt | input | 1 | Undervoltage flag |
| overTemp | input | 1 | Over-temperature flag |
| deadCycles | input | DEAD_W | Blanking length after a state change |
| srcOut | output | 3 | Source-side enables, bit0 = U, bit1 = V, bit2 = W |
| snkOut | output | 3 | Sink-side enables, bit0 = U, bit1 = V, bit2 = W |
| auxOut | output | 1 | PWM signal or conditioned tachometer level |

## Verification
The bench builds the block with SYNC_STAGES = 2 and DEAD_W = 8. With these values a Hall edge reaches the outputs after three clock edges, and a blanking window of four cycles can be checked at both of its ends within a few cycles. The two-stage chain also lets the bench count the tachometer latency seen on `auxOut` exactly. The eight-bit dead-time field puts both the zero-blanking case and a nonzero window in reach of directed tests, including a blanking window started by a direction flip rather than a Hall edge.

// File: rtl/hcomm_pkg.sv
package hcomm_pkg;
  localparam int PHASES = 3;

  typedef struct packed {
    logic blank;     // dead-time window active
    logic killAll;   // stop or over-temperature
    logic killSink;  // undervoltage or lock latch
    logic chop;      // direct-PWM mode
  } hcommStrobe_t;
endpackage

// File: rtl/hcomm_sync.sv
module hcomm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/hcomm_ctrl.sv
module hcomm_ctrl
  import hcomm_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hallSync,
  input  logic              dirRev,
  input  logic              stopReq,
  input  logic              modeAmp,
  input  logic              underVolt,
  input  logic              lockTrip,
  input  logic              overTemp,
  input  logic [DEAD_W-1:0] deadCycles,
  output hcommStrobe_t      strobe
);
  localparam int KEY_W = PHASES + 1;

  logic [KEY_W-1:0]  keyNow, keyLast;
  logic              keyChange;
  logic [DEAD_W-1:0] deadCnt;

  assign keyNow    = {dirRev, hallSync};
  assign keyChange = (keyNow != keyLast);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) keyLast <= '0;
    else       keyLast <= keyNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      deadCnt <= '0;
    else if (keyChange)
      deadCnt <= (deadCycles == '0) ? '0 : deadCycles - 1'b1;
    else if (deadCnt != '0)
      deadCnt <= deadCnt - 1'b1;
  end

  always_comb begin
    strobe.blank    = (keyChange && deadCycles != '0) || (deadCnt != '0);
    strobe.killAll  = stopReq | overTemp;
    strobe.killSink = underVolt | lockTrip;
    strobe.chop     = ~modeAmp;
  end

  // R5
  dead_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deadCnt != '0 && !keyChange) |=> deadCnt == DEAD_W'($past(deadCnt) - 1'b1));

  // R5
  dead_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyChange && deadCycles != '0) |=> deadCnt == DEAD_W'($past(deadCycles) - 1'b1));
endmodule

// File: rtl/hcomm_datapath.sv
module hcomm_datapath
  import hcomm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hallSync,
  input  logic              dirRev,
  input  logic              pwmIn,
  input  logic              tachSync,
  input  hcommStrobe_t      strobe,
  output logic [PHASES-1:0] srcOut,
  output logic [PHASES-1:0] snkOut,
  output logic              auxOut
);
  localparam logic [PHASES-1:0] PH_U = 3'b001;
  localparam logic [PHASES-1:0] PH_V = 3'b010;
  localparam logic [PHASES-1:0] PH_W = 3'b100;

  logic [PHASES-1:0] rowIdx, srcDec, snkDec, srcNext, snkNext;
  logic              invalid, offAll;

  assign rowIdx = hallSync ^ {PHASES{dirRev}};

  always_comb begin
    srcDec = '0;
    snkDec = '0;
    case (rowIdx)
      3'b101: begin srcDec = PH_V; snkDec = PH_U; end
      3'b100: begin srcDec = PH_W; snkDec = PH_U; end
      3'b110: begin srcDec = PH_W; snkDec = PH_V; end
      3'b010: begin srcDec = PH_U; snkDec = PH_V; end
      3'b011: begin srcDec = PH_U; snkDec = PH_W; end
      3'b001: begin srcDec = PH_V; snkDec = PH_W; end
      default: begin srcDec = '0; snkDec = '0; end
    endcase
  end

  assign invalid = (srcDec == '0);
  assign offAll  = strobe.killAll | strobe.blank | invalid;

  always_comb begin
    srcNext = offAll ? '0 : (srcDec & (strobe.chop ? {PHASES{pwmIn}} : {PHASES{1'b1}}));
    snkNext = (offAll | strobe.killSink) ? '0 : snkDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcOut <= '0;
      snkOut <= '0;
      auxOut <= 1'b0;
    end else begin
      srcOut <= srcNext;
      snkOut <= snkNext;
      auxOut <= strobe.chop ? tachSync : pwmIn;
    end
  end

  // R10
  one_per_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcOut) && $onehot0(snkOut));

  // R10
  no_phase_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcOut & snkOut) == '0);

  // R9
  kill_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killAll |=> (srcOut == '0 && snkOut == '0));

  // R8
  kill_sink_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killSink |=> snkOut == '0);

  // R5
  blank_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blank |=> (srcOut == '0 && snkOut == '0));

  // R6
  chop_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.chop && !pwmIn) |=> srcOut == '0);

  // R7
  aux_amp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.chop |=> auxOut == $past(pwmIn));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcomm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hallIn,
  input  logic              tachIn,
  input  logic              dirRev,
  input  logic              stopReq,
  input  logic              modeAmp,
  input  logic              pwmIn,
  input  logic              lockTrip,
  input  logic              underVolt,
  input  logic              overTemp,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic [2:0]        srcOut,
  output logic [2:0]        snkOut,
  output logic              auxOut
);
  localparam int SYNC_W = PHASES + 1;

  logic [SYNC_W-1:0] syncOut;
  logic [PHASES-1:0] hallSync;
  logic              tachSync;
  hcommStrobe_t      strobe;

  hcomm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({tachIn, hallIn}),
    .dout (syncOut)
  );

  assign hallSync = syncOut[PHASES-1:0];
  assign tachSync = syncOut[SYNC_W-1];

  hcomm_ctrl #(.DEAD_W(DEAD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hallSync   (hallSync),
    .dirRev     (dirRev),
    .stopReq    (stopReq),
    .modeAmp    (modeAmp),
    .underVolt  (underVolt),
    .lockTrip   (lockTrip),
    .overTemp   (overTemp),
    .deadCycles (deadCycles),
    .strobe     (strobe)
  );

  hcomm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hallSync (hallSync),
    .dirRev   (dirRev),
    .pwmIn    (pwmIn),
    .tachSync (tachSync),
    .strobe   (strobe),
    .srcOut   (srcOut),
    .snkOut   (snkOut),
    .auxOut   (auxOut)
  );
endmodule

// File: tb/hall_commutator_test.sv
`timescale 1ns/1ps
module hall_commutator_test;
  localparam int SYNC_STAGES = 2;
  localparam int DEAD_W      = 8;
  localparam int HALL_LAT    = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] hallIn;
  logic tachIn, dirRev, stopReq, modeAmp, pwmIn, lockTrip, underVolt, overTemp;
  logic [DEAD_W-1:0] deadCycles;
  logic [2:0] srcOut, snkOut;
  logic auxOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  hall_commutator #(.SYNC_STAGES(SYNC_STAGES), .DEAD_W(DEAD_W)) uut (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .tachIn(tachIn), .dirRev(dirRev),
    .stopReq(stopReq), .modeAmp(modeAmp), .pwmIn(pwmIn), .lockTrip(lockTrip),
    .underVolt(underVolt), .overTemp(overTemp), .deadCycles(deadCycles),
    .srcOut(srcOut), .snkOut(snkOut), .auxOut(auxOut)
  );

  // Phase bits: bit0 U, bit1 V, bit2 W. Row chosen by code, complemented in reverse.
  function automatic logic [5:0] expectPair(input logic [2:0] code, input logic rev);
    logic [2:0] row;
    row = rev ? ~code : code;
    case (row)
      3'b010: return {3'b001, 3'b010};
      3'b011: return {3'b001, 3'b100};
      3'b101: return {3'b010, 3'b001};
      3'b001: return {3'b010, 3'b100};
      3'b100: return {3'b100, 3'b001};
      3'b110: return {3'b100, 3'b010};
      default: return 6'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkPair(input string tag, input logic [2:0] code, input logic rev);
    logic [5:0] e;
    e = expectPair(code, rev);
    check({tag, " src"}, srcOut, e[5:3]);
    check({tag, " snk"}, snkOut, e[2:0]);
  endtask

  task automatic test_reset();
    waitEdges(2);
    check("R11 reset src", srcOut, 3'b000);
    check("R11 reset snk", snkOut, 3'b000);
    check("R11 reset aux", {2'b00, auxOut}, 3'b000);
  endtask

  task automatic test_forward();
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    dirRev = 1'b0;
    stopReq = 1'b0;
    foreach (seq[i]) begin
      hallIn = seq[i];
      waitEdges(HALL_LAT);
      checkPair("R1 forward", seq[i], 1'b0);
      check("R10 exclusive", srcOut & snkOut, 3'b000);
      check("R10 one each", {1'b0, ($countones(srcOut) == 1), ($countones(snkOut) == 1)}, 3'b011);
    end
  endtask

  task automatic test_reverse();
    logic [2:0] seq [6] = '{3'b010, 3'b011, 3'b001, 3'b101, 3'b100, 3'b110};
    dirRev = 1'b1;
    foreach (seq[i]) begin
      hallIn = seq[i];
      waitEdges(HALL_LAT);
      checkPair("R2 reverse", seq[i], 1'b1);
      check("R10 exclusive rev", srcOut & snkOut, 3'b000);
    end
    hallIn = 3'b010;
    waitEdges(HALL_LAT);
    check("R2 rev 010 src=V", srcOut, 3'b010);
    check("R2 rev 010 snk=U", snkOut, 3'b001);
    dirRev = 1'b0;
    waitEdges(1);
  endtask

  task automatic test_invalid();
    hallIn = 3'b000;
    waitEdges(HALL_LAT);
    check("R3 code000 src", srcOut, 3'b000);
    check("R3 code000 snk", snkOut, 3'b000);
    hallIn = 3'b111;
    waitEdges(HALL_LAT);
    check("R3 code111 src", srcOut, 3'b000);
    check("R3 code111 snk", snkOut, 3'b000);
  endtask

  task automatic test_stop();
    hallIn = 3'b110;
    waitEdges(HALL_LAT);
    stopReq = 1'b1;
    waitEdges(1);
    check("R4 stop src", srcOut, 3'b000);
    check("R4 stop snk", snkOut, 3'b000);
    stopReq = 1'b0;
    waitEdges(1);
    checkPair("R4 run", 3'b110, 1'b0);
  endtask

  task automatic test_deadtime();
    deadCycles = 8'd4;
    hallIn = 3'b011;
    waitEdges(HALL_LAT);
    check("R5 blank first src", srcOut, 3'b000);
    check("R5 blank first snk", snkOut, 3'b000);
    waitEdges(3);
    check("R5 blank last src", srcOut, 3'b000);
    waitEdges(1);
    checkPair("R5 after blank", 3'b011, 1'b0);
    dirRev = 1'b1;
    waitEdges(4);
    check("R5 dir blank src", srcOut, 3'b000);
    waitEdges(1);
    checkPair("R5 dir after blank", 3'b011, 1'b1);
    deadCycles = 8'd0;
    dirRev = 1'b0;
    waitEdges(1);
    checkPair("R5 zero dead", 3'b011, 1'b0);
  endtask

  task automatic test_direct_pwm();
    hallIn = 3'b101;
    modeAmp = 1'b0;
    pwmIn = 1'b1;
    waitEdges(HALL_LAT);
    checkPair("R6 pwm high", 3'b101, 1'b0);
    pwmIn = 1'b0;
    waitEdges(1);
    check("R6 pwm low src", srcOut, 3'b000);
    check("R6 pwm low snk", snkOut, 3'b001);
    tachIn = 1'b1;
    waitEdges(HALL_LAT);
    check("R7 aux tach high", {2'b00, auxOut}, 3'b001);
    tachIn = 1'b0;
    waitEdges(HALL_LAT);
    check("R7 aux tach low", {2'b00, auxOut}, 3'b000);
  endtask

  task automatic test_amp_mode();
    modeAmp = 1'b1;
    pwmIn = 1'b0;
    tachIn = 1'b1;
    waitEdges(HALL_LAT);
    check("R7 amp no chop src", srcOut, 3'b010);
    check("R7 amp aux=pwm0", {2'b00, auxOut}, 3'b000);
    pwmIn = 1'b1;
    waitEdges(1);
    check("R7 amp aux=pwm1", {2'b00, auxOut}, 3'b001);
    tachIn = 1'b0;
  endtask

  task automatic test_sink_kill();
    underVolt = 1'b1;
    waitEdges(1);
    check("R8 uv snk", snkOut, 3'b000);
    check("R8 uv src", srcOut, 3'b010);
    underVolt = 1'b0;
    lockTrip = 1'b1;
    waitEdges(1);
    check("R8 lock snk", snkOut, 3'b000);
    check("R8 lock src", srcOut, 3'b010);
    lockTrip = 1'b0;
    waitEdges(1);
    checkPair("R8 release", 3'b101, 1'b0);
  endtask

  task automatic test_overtemp();
    overTemp = 1'b1;
    waitEdges(3);
    check("R9 ot src", srcOut, 3'b000);
    check("R9 ot snk", snkOut, 3'b000);
    overTemp = 1'b0;
    waitEdges(1);
    checkPair("R9 ot release", 3'b101, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    hallIn = 3'b101; tachIn = 1'b0; dirRev = 1'b0; stopReq = 1'b1; modeAmp = 1'b1;
    pwmIn = 1'b0; lockTrip = 1'b0; underVolt = 1'b0; overTemp = 1'b0; deadCycles = '0;
    test_reset();
    rstN = 1'b1;
    waitEdges(HALL_LAT);
    test_forward();
    test_reverse();
    test_invalid();
    test_stop();
    test_deadtime();
    test_direct_pwm();
    test_amp_mode();
    test_sink_kill();
    test_overtemp();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end
endmodule